// File: doc/BRIEF.md
# Streaming Mailbox Register Block with CRC32C Readback

This block is a small memory-mapped register file placed in front of a byte-addressed transfer buffer. A host sizes the buffer through a size register, then streams bytes in or out through a single data port. Each data-port access moves 1, 2, 4 or 8 bytes at an internal offset and moves that offset on by the access width. Once a transfer is done, the host reads a CRC32C register. The block then walks the buffer from byte 0 up to the current offset, one byte per clock, and returns the checksum. The host compares it with its own checksum to confirm the transfer.

Commands go through a command/status register. A command runs in the cycle its write is accepted, and its status code stays latched until the next command. One command clears the configuration and the buffer. Another rewinds the offset to zero. Every other code reports not-supported, including the two transfer-mode codes, whose payload handling lies outside this block. The register file also holds a fixed identification word, a flags word and two 32-bit halves of a buffer address, which are plain storage.

The bus is a simple strobe interface. A read or write strobe is accepted at a rising clock edge while `bus_ready` is high, and read data appears on `bus_rdata` after that edge. The only multi-cycle access is a CRC read. The block is controlled by a two-state machine: `ST_IDLE` accepts accesses, and `ST_CRC` walks the buffer. It moves `ST_IDLE -> ST_CRC` when a CRC read is accepted, and `ST_CRC -> ST_IDLE` when the walk index reaches the offset.

Top module: `mbx_regs`

## Requirements
- R1: A data-port access (address 0x14) with `bus_size` code 0, 1, 2 or 3 transfers 1, 2, 4 or 8 bytes, little-endian, at the current offset. Byte k of the access sits in `bus_wdata`/`bus_rdata` bits [8k+7:8k], and the unused upper bits of a read are 0. The offset then advances by the byte count.
- R2: When offset plus byte count exceeds the configured size, a data-port read returns 0, a data-port write changes no buffer byte, and the offset stays where it was.
- R3: A write to the size register (0x08) stores the written value clamped to MAX_BYTES (64 by default) and clears every buffer byte to 0. Reading the register returns the stored size.
- R4: A read of the CRC register (0x18) returns, in bits [31:0], the reflected CRC32C (polynomial 0x82F63B78) with seed 0xFFFFFFFF and no final inversion, computed over buffer bytes 0 to offset-1. The offset is left unchanged.
- R5: After a CRC read is accepted, `bus_ready` stays low for exactly offset+1 cycles, and no access is accepted while it is low. The result is on `bus_rdata` when `bus_ready` returns high.
- R6: A write to the command register (0x04) executes the command held in `bus_wdata[31:0]` and latches its status. A read of 0x04 returns the last status. Status codes are 0 for success, 1 for not-supported and 2 for bad-size; bad-size is reserved.
- R7: Command 0 clears the size, both address halves and the buffer, leaves the offset alone, and reports status 0.
- R8: Command 1 sets the offset to 0 and reports status 0. Commands 2 and 3 (transfer modes) and every other code report status 1.
- R9: The address halves (low 0x0C, high 0x10) are 32-bit read/write registers. `bus_wdata[31:0]` is stored, and reads return it zero-extended.
- R10: Reading 0x00 returns the identification word 0x4D425843, and reading 0x1C returns the flags word 0x00000001. Any address outside the map reads all ones. Writes to 0x00, 0x18, 0x1C and to addresses outside the map change nothing.
- R11: An active-low `rst_n` clears every register, the offset, the buffer and the latched status, and returns the machine to `ST_IDLE`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 64 | Write data |
| bus_size | input | 2 | Access width code: bytes = 1 << code |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe (wins over a simultaneous read) |
| bus_rdata | output | 64 | Read data of the last completed read |
| bus_ready | output | 1 | High when an access can be accepted |

## Verification
The bound checker checks, on every cycle, the rules that relate one accepted access to the next state: the offset steps by exactly the access width or holds on an overflow, an out-of-range read yields zero, the stored size never passes the clamp, `bus_ready` drops after a CRC read, the offset stays fixed during the walk, and the identification word is returned. The CRC value itself, the exact length of the busy window, little-endian byte placement across mixed widths, buffer clearing and the status codes of each command are shown only by the bench's scenarios. There, a reference model fed by random and directed traffic predicts each read.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int unsigned ADDR_W = 5;

    localparam logic [ADDR_W-1:0] REG_IDENT = 5'h00;
    localparam logic [ADDR_W-1:0] REG_CMD   = 5'h04;
    localparam logic [ADDR_W-1:0] REG_SIZE  = 5'h08;
    localparam logic [ADDR_W-1:0] REG_ALO   = 5'h0C;
    localparam logic [ADDR_W-1:0] REG_AHI   = 5'h10;
    localparam logic [ADDR_W-1:0] REG_DATA  = 5'h14;
    localparam logic [ADDR_W-1:0] REG_CRC   = 5'h18;
    localparam logic [ADDR_W-1:0] REG_FLAGS = 5'h1C;

    localparam logic [31:0] CMD_RESET  = 32'd0;
    localparam logic [31:0] CMD_REWIND = 32'd1;

    localparam logic [31:0] CRC_POLY = 32'h82F6_3B78;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_CRC  = 1'b1
    } mbx_state_e;

    typedef enum logic [1:0] {
        STS_OK      = 2'd0,
        STS_UNSUP   = 2'd1,
        STS_BADSIZE = 2'd2
    } mbx_sts_e;

    function automatic logic [31:0] crc32c_byte(input logic [31:0] c_in, input logic [7:0] b);
        logic [31:0] c;
        c = c_in ^ {24'h0, b};
        for (int i = 0; i < 8; i++) begin
            c = c[0] ? ((c >> 1) ^ CRC_POLY) : (c >> 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/mbx_crc.sv
module mbx_crc import mbx_pkg::*; (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        init,
    input  logic        step,
    input  logic [7:0]  byte_in,
    output logic [31:0] crc_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= 32'hFFFF_FFFF;
        end else if (init) begin
            crc_q <= 32'hFFFF_FFFF;
        end else if (step) begin
            crc_q <= crc32c_byte(crc_q, byte_in);
        end
    end
endmodule

// File: rtl/mbx_buf.sv
module mbx_buf #(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned OFF_W = 7,
    parameter int unsigned IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr_en,
    input  logic [OFF_W-1:0] acc_off,
    input  logic [3:0]       acc_nb,
    input  logic [63:0]      wr_data,
    output logic [63:0]      rd_data,
    input  logic [IDX_W-1:0] crc_idx,
    output logic [7:0]       crc_byte
);
    logic [7:0] mem_q [DEPTH];

    // Each byte decides on its own whether it lies inside the access window.
    for (genvar i = 0; i < DEPTH; i++) begin : g_byte
        logic [OFF_W:0] rel;
        logic           sel;
        assign rel = (OFF_W+1)'(i) - {1'b0, acc_off};
        assign sel = !rel[OFF_W] && (rel < (OFF_W+1)'(acc_nb));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem_q[i] <= 8'h00;
            end else if (clr) begin
                mem_q[i] <= 8'h00;
            end else if (wr_en && sel) begin
                mem_q[i] <= wr_data[8*rel[2:0] +: 8];
            end
        end
    end

    // Read lanes: lane k takes byte offset+k, little-endian.
    for (genvar k = 0; k < 8; k++) begin : g_lane
        logic [OFF_W:0] pos;
        assign pos = {1'b0, acc_off} + (OFF_W+1)'(k);
        assign rd_data[8*k +: 8] = ((4'(k) < acc_nb) && (pos < (OFF_W+1)'(DEPTH)))
                                   ? mem_q[pos[IDX_W-1:0]] : 8'h00;
    end

    assign crc_byte = mem_q[crc_idx];
endmodule

// File: rtl/mbx_regs.sv
module mbx_regs import mbx_pkg::*; #(
    parameter int unsigned MAX_BYTES = 64,
    parameter logic [31:0] MAGIC     = 32'h4D42_5843,
    parameter logic [31:0] FLAGS_VAL = 32'h0000_0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [63:0]       bus_wdata,
    input  logic [1:0]        bus_size,
    input  logic              bus_rd,
    input  logic              bus_wr,
    output logic [63:0]       bus_rdata,
    output logic              bus_ready
);
    localparam int unsigned OFF_W = $clog2(MAX_BYTES + 1);
    localparam int unsigned IDX_W = $clog2(MAX_BYTES);

    mbx_state_e       state_q, state_d;
    logic [OFF_W-1:0] off_q, size_q, idx_q;
    logic [31:0]      alo_q, ahi_q;
    mbx_sts_e         sts_q;
    logic [63:0]      rdata_q, port_rd, rd_word;
    logic [3:0]       nb;
    logic             acc_wr, acc_rd, fits, is_data;
    logic             size_wr, cmd_wr, rst_cmd, buf_clr, buf_wr;
    logic             crc_start, crc_step, crc_end;
    logic [7:0]       crc_byte;
    logic [31:0]      crc_val;

    assign nb        = 4'd1 << bus_size;
    assign bus_ready = (state_q == ST_IDLE);
    assign acc_wr    = bus_ready && bus_wr;
    assign acc_rd    = bus_ready && bus_rd && !bus_wr;
    assign is_data   = (bus_addr == REG_DATA);
    assign fits      = ({1'b0, off_q} + (OFF_W+1)'(nb)) <= {1'b0, size_q};
    assign size_wr   = acc_wr && (bus_addr == REG_SIZE);
    assign cmd_wr    = acc_wr && (bus_addr == REG_CMD);
    assign rst_cmd   = cmd_wr && (bus_wdata[31:0] == CMD_RESET);
    assign buf_clr   = size_wr || rst_cmd;
    assign buf_wr    = acc_wr && is_data && fits;
    assign crc_start = acc_rd && (bus_addr == REG_CRC);
    assign crc_step  = (state_q == ST_CRC) && (idx_q != off_q);
    assign crc_end   = (state_q == ST_CRC) && (idx_q == off_q);
    assign bus_rdata = rdata_q;

    mbx_buf #(.DEPTH(MAX_BYTES), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (buf_clr),
        .wr_en    (buf_wr),
        .acc_off  (off_q),
        .acc_nb   (nb),
        .wr_data  (bus_wdata),
        .rd_data  (port_rd),
        .crc_idx  (idx_q[IDX_W-1:0]),
        .crc_byte (crc_byte)
    );

    mbx_crc u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .init    (crc_start),
        .step    (crc_step),
        .byte_in (crc_byte),
        .crc_q   (crc_val)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (crc_start) state_d = ST_CRC;
            ST_CRC:  if (crc_end)   state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Read multiplexer
    always_comb begin
        case (bus_addr)
            REG_IDENT: rd_word = {32'h0, MAGIC};
            REG_CMD:   rd_word = 64'(sts_q);
            REG_SIZE:  rd_word = 64'(size_q);
            REG_ALO:   rd_word = {32'h0, alo_q};
            REG_AHI:   rd_word = {32'h0, ahi_q};
            REG_DATA:  rd_word = fits ? port_rd : 64'h0;
            REG_CRC:   rd_word = rdata_q;
            REG_FLAGS: rd_word = {32'h0, FLAGS_VAL};
            default:   rd_word = '1;
        endcase
    end

    // Register and output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_q   <= '0;
            size_q  <= '0;
            idx_q   <= '0;
            alo_q   <= '0;
            ahi_q   <= '0;
            sts_q   <= STS_OK;
            rdata_q <= '0;
        end else begin
            if (acc_rd && !crc_start) rdata_q <= rd_word;
            if (crc_end)              rdata_q <= {32'h0, crc_val};
            if (crc_start)            idx_q   <= '0;
            else if (crc_step)        idx_q   <= idx_q + 1'b1;
            if ((acc_wr || acc_rd) && is_data && fits)
                off_q <= off_q + OFF_W'(nb);
            if (size_wr)
                size_q <= (bus_wdata > 64'(MAX_BYTES)) ? OFF_W'(MAX_BYTES)
                                                       : bus_wdata[OFF_W-1:0];
            if (acc_wr && bus_addr == REG_ALO) alo_q <= bus_wdata[31:0];
            if (acc_wr && bus_addr == REG_AHI) ahi_q <= bus_wdata[31:0];
            if (cmd_wr) begin
                if (rst_cmd) begin
                    size_q <= '0;
                    alo_q  <= '0;
                    ahi_q  <= '0;
                    sts_q  <= STS_OK;
                end else if (bus_wdata[31:0] == CMD_REWIND) begin
                    off_q  <= '0;
                    sts_q  <= STS_OK;
                end else begin
                    sts_q  <= STS_UNSUP;
                end
            end
        end
    end
endmodule

// File: rtl/mbx_regs_chk.sv
module mbx_regs_chk import mbx_pkg::*; #(
    parameter int unsigned MAX_BYTES = 64,
    parameter int unsigned OFF_W     = 7,
    parameter logic [31:0] MAGIC     = 32'h4D42_5843
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [63:0]       bus_wdata,
    input logic [1:0]        bus_size,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [63:0]       bus_rdata,
    input logic              bus_ready,
    input logic [OFF_W-1:0]  off_q,
    input logic [OFF_W-1:0]  size_q
);
    logic [3:0] c_nb;
    logic       c_data_acc, c_in, c_rd;

    assign c_nb       = 4'd1 << bus_size;
    assign c_rd       = bus_ready && bus_rd && !bus_wr;
    assign c_data_acc = bus_ready && (bus_rd || bus_wr) && (bus_addr == REG_DATA);
    assign c_in       = (32'(off_q) + 32'(c_nb)) <= 32'(size_q);

    a_r1_offset_step: assert property (@(posedge clk) disable iff (!rst_n)
        c_data_acc && c_in |=> off_q == $past(off_q) + OFF_W'($past(c_nb)));

    a_r2_offset_hold: assert property (@(posedge clk) disable iff (!rst_n)
        c_data_acc && !c_in |=> $stable(off_q));

    a_r2_oob_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        c_rd && bus_addr == REG_DATA && !c_in |=> bus_rdata == 64'h0);

    a_r3_size_limit: assert property (@(posedge clk) disable iff (!rst_n)
        32'(size_q) <= MAX_BYTES);

    a_r3_size_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready && bus_wr && bus_addr == REG_SIZE |=>
        64'(size_q) == (($past(bus_wdata) > 64'(MAX_BYTES)) ? 64'(MAX_BYTES) : $past(bus_wdata)));

    a_r4_walk_keeps_offset: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ready |-> $stable(off_q));

    a_r5_busy_after_crc: assert property (@(posedge clk) disable iff (!rst_n)
        c_rd && bus_addr == REG_CRC |=> !bus_ready);

    a_r7_reset_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready && bus_wr && bus_addr == REG_CMD && bus_wdata[31:0] == CMD_RESET |=> size_q == '0);

    a_r10_ident: assert property (@(posedge clk) disable iff (!rst_n)
        c_rd && bus_addr == REG_IDENT |=> bus_rdata == {32'h0, MAGIC});
endmodule

bind mbx_regs mbx_regs_chk #(.MAX_BYTES(MAX_BYTES), .OFF_W(OFF_W), .MAGIC(MAGIC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_size  (bus_size),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_rdata (bus_rdata),
    .bus_ready (bus_ready),
    .off_q     (off_q),
    .size_q    (size_q)
);

// File: tb/test_mbx_regs.sv
`timescale 1ns/1ps
module test_mbx_regs;
    import mbx_pkg::*;

    localparam int          MAXB      = 64;
    localparam logic [31:0] MAGIC_EXP = 32'h4D42_5843;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [63:0] bus_wdata = '0;
    logic [1:0]  bus_size = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [63:0] bus_rdata;
    logic        bus_ready;

    int checks = 0;
    int errors = 0;

    logic [7:0]  mbuf [MAXB];
    int          moff, msize, mstat;
    logic [31:0] mlo, mhi;

    always #2.5 clk = ~clk;

    mbx_regs i_mbx_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_size  (bus_size),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_rdata (bus_rdata),
        .bus_ready (bus_ready)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic void mdl_clear_buf();
        for (int i = 0; i < MAXB; i++) mbuf[i] = 8'h00;
    endfunction

    function automatic void mdl_reset();
        mdl_clear_buf();
        moff = 0; msize = 0; mstat = 0; mlo = '0; mhi = '0;
    endfunction

    function automatic logic [31:0] crc_model(input int n);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < n; i++) begin
            c = c ^ {24'h0, mbuf[i]};
            for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'h82F6_3B78) : (c >> 1);
        end
        return c;
    endfunction

    function automatic void mdl_write(input logic [4:0] a, input logic [63:0] d, input logic [1:0] sz);
        int n = 1 << sz;
        case (a)
            REG_CMD: begin
                if (d[31:0] == 0) begin
                    msize = 0; mlo = '0; mhi = '0; mdl_clear_buf(); mstat = 0;
                end else if (d[31:0] == 1) begin
                    moff = 0; mstat = 0;
                end else mstat = 1;
            end
            REG_SIZE: begin
                msize = (d > 64'(MAXB)) ? MAXB : int'(d);
                mdl_clear_buf();
            end
            REG_ALO: mlo = d[31:0];
            REG_AHI: mhi = d[31:0];
            REG_DATA: if (moff + n <= msize) begin
                for (int k = 0; k < n; k++) mbuf[moff+k] = d[8*k +: 8];
                moff += n;
            end
            default: ;
        endcase
    endfunction

    function automatic logic [63:0] mdl_read(input logic [4:0] a, input logic [1:0] sz);
        int n = 1 << sz;
        logic [63:0] r = '0;
        case (a)
            REG_IDENT: r = {32'h0, MAGIC_EXP};
            REG_CMD:   r = 64'(mstat);
            REG_SIZE:  r = 64'(msize);
            REG_ALO:   r = {32'h0, mlo};
            REG_AHI:   r = {32'h0, mhi};
            REG_DATA: if (moff + n <= msize) begin
                for (int k = 0; k < n; k++) r[8*k +: 8] = mbuf[moff+k];
                moff += n;
            end
            REG_CRC:   r = {32'h0, crc_model(moff)};
            REG_FLAGS: r = 64'h1;
            default:   r = '1;
        endcase
        return r;
    endfunction

    task automatic bus_op(input bit wr, input logic [4:0] a, input logic [63:0] d, input logic [1:0] sz,
                          output logic [63:0] rd, output int busy);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_size = sz; bus_wr = wr; bus_rd = !wr;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        busy = 0;
        while (!bus_ready) begin
            busy++;
            @(negedge clk);
        end
        rd = bus_rdata;
    endtask

    // Model-checked access: writes update the model, reads are compared with it.
    task automatic op(input bit wr, input logic [4:0] a, input logic [63:0] d, input logic [1:0] sz, input string req);
        logic [63:0] rd, exp;
        int busy, exp_busy;
        exp_busy = moff + 1;
        if (wr) begin
            bus_op(1'b1, a, d, sz, rd, busy);
            mdl_write(a, d, sz);
        end else begin
            exp = mdl_read(a, sz);
            bus_op(1'b0, a, d, sz, rd, busy);
            check(rd == exp, req, rd, exp);
            if (a == REG_CRC) check(busy == exp_busy, "R5 busy window", 64'(busy), 64'(exp_busy));
        end
    endtask

    task automatic hard_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        mdl_reset();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] rd;
        int busy;
        void'($urandom(32'd20240611));
        mdl_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state
        op(0, REG_IDENT, 0, 2, "R11 ident");
        op(0, REG_CMD,   0, 2, "R11 status");
        op(0, REG_SIZE,  0, 2, "R11 size");
        op(0, REG_ALO,   0, 2, "R11 addr lo");
        op(0, REG_AHI,   0, 2, "R11 addr hi");
        op(0, REG_CRC,   0, 2, "R11 crc empty");
        op(0, REG_DATA,  0, 0, "R2 read with size 0");
        op(0, REG_FLAGS, 0, 2, "R10 flags");

        // R9 address halves
        op(1, REG_ALO, 64'hAAAA_BBBB_1234_5678, 3, "R9");
        op(1, REG_AHI, 64'h0000_0001_9ABC_DEF0, 3, "R9");
        op(0, REG_ALO, 0, 2, "R9 addr lo");
        op(0, REG_AHI, 0, 2, "R9 addr hi");

        // R3 clamp
        op(1, REG_SIZE, 64'd100, 2, "R3");
        op(0, REG_SIZE, 0, 2, "R3 clamp to max");

        // R4/R5 known vector "123456789"
        op(1, REG_SIZE, 64'd9, 2, "R3");
        for (int i = 0; i < 9; i++) op(1, REG_DATA, 64'(8'h31 + i), 0, "R1");
        bus_op(1'b0, REG_CRC, 0, 2, rd, busy);
        check(rd[31:0] == 32'h1CF9_6D7C, "R4 check vector", rd, 64'h1CF9_6D7C);
        check(busy == 10, "R5 ready low offset+1", 64'(busy), 64'd10);
        op(1, REG_DATA, 64'hFF, 0, "R2");
        op(0, REG_DATA, 0, 0, "R2 read past end");
        op(0, REG_CRC,  0, 2, "R4 offset unchanged by overflow");

        // R8 rewind, R1 little-endian widths
        op(1, REG_CMD, 64'd1, 2, "R8");
        op(0, REG_CMD, 0, 2, "R8 rewind status");
        op(0, REG_DATA, 0, 3, "R1 eight bytes");
        op(0, REG_DATA, 0, 1, "R2 two bytes overflow");
        op(0, REG_DATA, 0, 0, "R1 last byte");
        op(1, REG_CMD, 64'd1, 2, "R8");
        op(0, REG_DATA, 0, 1, "R1 two bytes");
        op(0, REG_DATA, 0, 2, "R1 four bytes");
        for (int c = 2; c < 6; c++) begin
            op(1, REG_CMD, 64'(c), 2, "R8");
            op(0, REG_CMD, 0, 2, "R8 unsupported code");
        end
        op(1, REG_CMD, 64'd1, 2, "R8");
        op(0, REG_CMD, 0, 2, "R6 status relatched");

        // R3 size write clears buffer
        op(1, REG_SIZE, 64'd16, 2, "R3");
        op(1, REG_CMD, 64'd1, 2, "R8");
        op(0, REG_DATA, 0, 3, "R3 cleared buffer");

        // R10 ignored writes
        op(1, REG_CMD, 64'd1, 2, "R8");
        op(1, REG_DATA, 64'h0102_0304_0506_0708, 3, "R1");
        op(1, REG_CRC,   64'h0, 2, "R10");
        op(1, REG_FLAGS, 64'h0, 2, "R10");
        op(1, REG_IDENT, 64'h0, 2, "R10");
        op(1, 5'h02,     64'h5, 2, "R10");
        op(1, 5'h1E,     64'h7, 2, "R10");
        op(0, REG_IDENT, 0, 2, "R10 ident after write");
        op(0, REG_FLAGS, 0, 2, "R10 flags after write");
        op(0, REG_SIZE,  0, 2, "R10 size untouched");
        op(0, REG_CRC,   0, 2, "R10 buffer and offset untouched");
        op(0, 5'h02,     0, 2, "R10 unmapped read");

        // R7 reset command
        op(1, REG_CMD, 64'd0, 2, "R7");
        op(0, REG_CMD,  0, 2, "R7 status");
        op(0, REG_SIZE, 0, 2, "R7 size");
        op(0, REG_ALO,  0, 2, "R7 addr lo");
        op(0, REG_AHI,  0, 2, "R7 addr hi");
        op(0, REG_CRC,  0, 2, "R7 offset kept");

        // Random traffic
        op(1, REG_SIZE, 64'd64, 2, "R3");
        op(1, REG_CMD, 64'd1, 2, "R8");
        for (int n = 0; n < 800; n++) begin
            int r = $urandom_range(0, 99);
            logic [1:0] sz = 2'($urandom_range(0, 3));
            logic [63:0] d = {$urandom, $urandom};
            if (r < 40)      op(1, REG_DATA, d, sz, "R1");
            else if (r < 65) op(0, REG_DATA, 0, sz, "R1 random read");
            else if (r < 73) op(0, REG_CRC, 0, 2, "R4 random crc");
            else if (r < 81) begin
                int code = ($urandom_range(0, 19) == 0) ? 0 : $urandom_range(1, 5);
                op(1, REG_CMD, 64'(code), 2, "R6");
                op(0, REG_CMD, 0, 2, "R6 random status");
            end
            else if (r < 85) op(1, REG_SIZE, 64'($urandom_range(0, 80)), 2, "R3");
            else if (r < 89) op(1, ($urandom_range(0, 1) != 0) ? REG_ALO : REG_AHI, d, 3, "R9");
            else if (r < 92) op(1, 5'($urandom_range(0, 31)), d, sz, "R10");
            else             op(0, 5'($urandom_range(0, 31)), 0, sz, "R10 random read");
        end

        // R11 hard reset after traffic
        op(1, REG_SIZE, 64'd32, 2, "R3");
        op(1, REG_DATA, 64'hDEAD_BEEF_CAFE_F00D, 3, "R1");
        hard_reset();
        op(0, REG_SIZE, 0, 2, "R11 size cleared");
        op(0, REG_CRC,  0, 2, "R11 offset cleared");
        op(0, REG_CMD,  0, 2, "R11 status cleared");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule